// File: doc/BRIEF.md
# Prioritised Interrupt Request Arbiter

The block collects up to 63 interrupt request lines, numbered 1 to 63; line 0 has no source behind it. Each line can be blocked by its own mask bit and carries an eight-bit control byte that sets an interrupt level (1 to 7, with 0 meaning "never requests") and a priority within that level. Every clock the block picks the most urgent pending, unblocked line. It then presents that line's level and source number to the processor on registered outputs.

Software programs the block through a small synchronous register bus. Writes take effect on the clock edge, and reads return the addressed register combinationally. The block provides two 32-bit block registers. Bit 0 of the low one is a global kill switch, because line 0 does not exist. It also provides one control byte per line at a fixed base plus the line number, and two read-only views of the raw request lines.

Top module: `irq_arbiter_top`

## Requirements
- R1: After reset the low block register reads 0x00000001, the high block register reads 0xFFFFFFFF, every control byte reads 0, and both outputs are 0.
- R2: Bus word address 0x00 holds the low block register, which covers lines 0 to 31 at bit n. Address 0x01 holds the high block register, which covers lines 32 to 63 at bit n-32. A write stores all 32 bits, and a read returns them.
- R3: A block bit at 1 stops its line from competing, and a block bit at 0 lets it compete.
- R4: While bit 0 of the low block register is 1, no line competes and the level output is 0.
- R5: The control byte of line n sits at bus address 0x40+n and is written from wdata[7:0]. Bits 5:3 hold the level and bits 2:0 hold the priority. A read returns the stored byte zero-extended to 32 bits.
- R6: A line whose level field is 0 never competes, and this includes an unconfigured line with a zero byte.
- R7: Among competing lines the winner has the highest level, and within a level the highest priority. The outputs give the winner's level and its number.
- R8: The outputs are registered. They reflect the request lines and registers as they stood before the previous rising clock edge.
- R9: Addresses 0x02 and 0x03 read the raw request lines 0 to 31 and 32 to 63 before any blocking. Writes to them change nothing.
- R10: Line 0 never competes, whatever its request, block bit or control byte.
- R11: When no line competes, both the level output and the source output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 64 | Raw request lines; bit 0 has no source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_level | output | 3 | Level of the winning line, 0 when idle |
| irq_src | output | 6 | Number of the winning line, 0 when idle |

## Verification
The assertions assume that software gives every configured line a distinct level-and-priority pair, so that no two competing lines tie. The stimulus meets this by deriving each byte from a bijection of the line number onto the 56 nonzero-level codes and leaving the other lines at zero. They also assume that request lines change only between clock edges. The bench drives all inputs on the falling edge, so each registered output depends on exactly one sampled state.

// File: rtl/irq_arbiter_pkg.sv
package irq_arbiter_pkg;
  localparam int NUM_LINES = 64;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int HALF_W    = 32;
  localparam int CTRL_W    = 8;
  localparam int LVL_W     = 3;
  localparam int KEY_W     = 6;
  localparam int ADDR_W    = 8;

  localparam logic [ADDR_W-1:0] A_BLK_LO  = 8'h00;
  localparam logic [ADDR_W-1:0] A_BLK_HI  = 8'h01;
  localparam logic [ADDR_W-1:0] A_PEND_LO = 8'h02;
  localparam logic [ADDR_W-1:0] A_PEND_HI = 8'h03;
  localparam logic [ADDR_W-1:0] A_CTRL    = 8'h40;

  typedef logic [CTRL_W-1:0] ctrl_t;

  function automatic logic [LVL_W-1:0] ctrl_level(ctrl_t b);
    return b[5:3];
  endfunction

  function automatic logic [KEY_W-1:0] ctrl_key(ctrl_t b);
    return {b[5:3], b[2:0]};
  endfunction

  function automatic logic is_ctrl_addr(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_W] == A_CTRL[ADDR_W-1:LINE_W];
  endfunction
endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_arbiter_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [HALF_W-1:0]     wdata,
  input  logic [NUM_LINES-1:0]  req,
  output logic [HALF_W-1:0]     rdata,
  output logic [NUM_LINES-1:0]  block,
  output ctrl_t                 ctrl [NUM_LINES]
);
  logic [HALF_W-1:0] blk_lo, blk_hi;
  logic wr_lo, wr_hi, wr_ctrl;

  assign wr_lo   = wr && addr == A_BLK_LO;
  assign wr_hi   = wr && addr == A_BLK_HI;
  assign wr_ctrl = wr && is_ctrl_addr(addr);
  assign block   = {blk_hi, blk_lo};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_lo <= HALF_W'(1);
      blk_hi <= '1;
    end else begin
      if (wr_lo) blk_lo <= wdata;
      if (wr_hi) blk_hi <= wdata;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl[g] <= '0;
      else if (wr_ctrl && addr[LINE_W-1:0] == LINE_W'(g)) ctrl[g] <= wdata[CTRL_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == A_BLK_LO)       rdata = blk_lo;
    else if (addr == A_BLK_HI)  rdata = blk_hi;
    else if (addr == A_PEND_LO) rdata = req[HALF_W-1:0];
    else if (addr == A_PEND_HI) rdata = req[NUM_LINES-1:HALF_W];
    else if (is_ctrl_addr(addr)) rdata = HALF_W'(ctrl[addr[LINE_W-1:0]]);
  end

  assert_blk_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> blk_lo == $past(wdata));
  assert_blk_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> blk_hi == $past(wdata));
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arbiter_pkg::*;
(
  input  logic [NUM_LINES-1:0] req,
  input  logic [NUM_LINES-1:0] block,
  input  ctrl_t                ctrl [NUM_LINES],
  output logic [NUM_LINES-1:0] eligible,
  output logic                 any_eligible,
  output logic [LVL_W-1:0]     win_level,
  output logic [LINE_W-1:0]    win_line
);
  logic kill_all;
  assign kill_all = block[0];

  assign eligible[0] = 1'b0;
  for (genvar g = 1; g < NUM_LINES; g++) begin : g_elig
    assign eligible[g] = req[g] && !block[g] && !kill_all && ctrl_level(ctrl[g]) != '0;
  end

  assign any_eligible = |eligible;

  always_comb begin
    logic [KEY_W-1:0] best;
    best      = '0;
    win_line  = '0;
    win_level = '0;
    for (int i = 1; i < NUM_LINES; i++) begin
      if (eligible[i] && ctrl_key(ctrl[i]) > best) begin
        best      = ctrl_key(ctrl[i]);
        win_line  = LINE_W'(i);
        win_level = ctrl_level(ctrl[i]);
      end
    end
  end
endmodule

// File: rtl/irq_arbiter_top.sv
module irq_arbiter_top
  import irq_arbiter_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [63:0]          irq_req,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [2:0]           irq_level,
  output logic [5:0]           irq_src
);
  logic [NUM_LINES-1:0] block;
  logic [NUM_LINES-1:0] eligible;
  ctrl_t                ctrl [NUM_LINES];
  logic                 any_eligible;
  logic [LVL_W-1:0]     win_level;
  logic [LINE_W-1:0]    win_line;

  irq_regfile u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (bus_wr),
    .addr  (bus_addr),
    .wdata (bus_wdata),
    .req   (irq_req),
    .rdata (bus_rdata),
    .block (block),
    .ctrl  (ctrl)
  );

  irq_select u_sel (
    .req          (irq_req),
    .block        (block),
    .ctrl         (ctrl),
    .eligible     (eligible),
    .any_eligible (any_eligible),
    .win_level    (win_level),
    .win_line     (win_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level <= '0;
      irq_src   <= '0;
    end else begin
      irq_level <= win_level;
      irq_src   <= win_line;
    end
  end

  assert_kill_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
    block[0] |=> irq_level == '0);
  assert_request_seen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    any_eligible |=> irq_level != '0);
  assert_idle_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !any_eligible |=> irq_level == '0);
  assert_idle_src_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level == '0 |-> irq_src == '0);
  assert_no_line0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level != '0 |-> irq_src != '0);
  assert_winner_unblocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any_eligible |-> !block[win_line]);
endmodule

// File: tb/irq_arbiter_top_test.sv
module irq_arbiter_top_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_req = '0;
  logic        bus_wr = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_level;
  logic [5:0]  irq_src;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  bit [63:0] m_block;
  int        m_ctrl [64];
  int        exp_level = 0;
  int        exp_src = 0;

  irq_arbiter_top uut (.*);

  always #5 clk = ~clk;

  task automatic check(bit ok, string tag, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // reference model: evaluates winner from pre-edge state, then applies write
  always @(posedge clk) begin
    if (!rst_n) begin
      m_block = {32'hFFFFFFFF, 32'h00000001};
      foreach (m_ctrl[i]) m_ctrl[i] = 0;
      exp_level = 0;
      exp_src = 0;
    end else begin
      int bk;
      bk = 0; exp_level = 0; exp_src = 0;
      for (int s = 1; s < 64; s++) begin
        int lv;
        lv = (m_ctrl[s] >> 3) & 7;
        if (irq_req[s] && !m_block[s] && !m_block[0] && lv != 0 && (m_ctrl[s] & 63) > bk) begin
          bk = m_ctrl[s] & 63;
          exp_level = lv;
          exp_src = s;
        end
      end
      if (bus_wr) begin
        if (bus_addr == 8'h00) m_block[31:0] = bus_wdata;
        else if (bus_addr == 8'h01) m_block[63:32] = bus_wdata;
        else if (bus_addr >= 8'h40 && bus_addr < 8'h80) m_ctrl[bus_addr - 8'h40] = bus_wdata & 255;
      end
    end
  end

  // per-cycle comparison of registered outputs (R7, R8, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      check(irq_level == exp_level[2:0], "R7/R8 level", irq_level, exp_level);
      check(irq_src == exp_src[5:0], "R7/R8 src", irq_src, exp_src);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] expv, string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata == expv, tag, bus_rdata, expv);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  function automatic int cfg_byte(int s);
    return ((s * 37) % 56) + 8;
  endfunction

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(8'h00, 32'h1, "R1 block low");
    rd(8'h01, 32'hFFFFFFFF, "R1 block high");
    rd(8'h45, 32'h0, "R1 ctrl byte");
    check(irq_level == 0 && irq_src == 0, "R1 outputs", {irq_level, irq_src}, 0);

    // R2 block register access
    wr(8'h00, 32'hA5A5A5A4); rd(8'h00, 32'hA5A5A5A4, "R2 low rw");
    wr(8'h01, 32'h12345678); rd(8'h01, 32'h12345678, "R2 high rw");

    // R5 configure lines 1..55 with unique codes
    for (int s = 1; s < 56; s++) wr(8'h40 + 8'(s), 32'hFFFFFF00 | 32'(cfg_byte(s)));
    rd(8'h40 + 8'd17, 32'(cfg_byte(17)), "R5 ctrl readback");
    wr(8'h00, 32'h0);
    wr(8'h01, 32'h0);

    // R7 / R5 single line decode
    @(negedge clk); irq_req = 64'(1) << 17;
    settle();
    check(irq_level == 3'(cfg_byte(17) >> 3), "R5 level field", irq_level, cfg_byte(17) >> 3);
    check(irq_src == 6'd17, "R7 single src", irq_src, 17);

    // R8 one-cycle latency on change
    @(negedge clk); irq_req = 64'(1) << 40;
    check(irq_src == 6'd17, "R8 old value held", irq_src, 17);
    @(negedge clk);
    check(irq_src == 6'd40, "R8 new value", irq_src, 40);

    // R7 random patterns, compared every cycle
    for (int k = 0; k < 300; k++) begin
      @(negedge clk); irq_req = {$urandom, $urandom};
    end

    // R3 block high half
    wr(8'h01, 32'hFFFFFFFF);
    @(negedge clk); irq_req = 64'hFFFFFFFF_00000000;
    settle();
    check(irq_level == 0, "R3 blocked lines", irq_level, 0);
    for (int k = 0; k < 100; k++) begin
      @(negedge clk); irq_req = {$urandom, $urandom};
    end
    wr(8'h01, 32'h0);

    // R4 kill-all bit
    wr(8'h00, 32'h1);
    @(negedge clk); irq_req = '1;
    settle();
    check(irq_level == 0 && irq_src == 0, "R4 kill all", irq_level, 0);
    wr(8'h00, 32'h0);
    settle();
    check(irq_level != 0, "R4 release", irq_level, 1);

    // R6 unconfigured lines only
    @(negedge clk); irq_req = 64'hFF000000_00000000;
    settle();
    check(irq_level == 0, "R6 zero level", irq_level, 0);

    // R10 line 0 with a nonzero byte
    wr(8'h40, 32'h3F);
    @(negedge clk); irq_req = 64'h1;
    settle();
    check(irq_level == 0 && irq_src == 0, "R10 line zero", irq_src, 0);
    check(irq_level == 0, "R11 idle level", irq_level, 0);

    // R9 raw pending view, write ignored
    @(negedge clk); irq_req = 64'hDEADBEEF_01234567;
    rd(8'h02, 32'h01234567, "R9 pend low");
    rd(8'h03, 32'hDEADBEEF, "R9 pend high");
    wr(8'h02, 32'h0);
    rd(8'h02, 32'h01234567, "R9 write ignored");
    rd(8'h00, 32'h0, "R9 block low unchanged");

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule